// File: doc/BRIEF.md
# Cross-Domain Latched 64-bit Counter

A free-running 64-bit counter advances on every rising edge of its own fixed-frequency counter clock, which has no phase or frequency relation to the bus clock. Software on an APB bus cannot sample the counter directly. It sets a self-clearing latch bit in a control register and then polls that bit. The block carries the request into the counter domain as a toggle and takes one snapshot of the full 64-bit value there. It then returns a completion toggle to the bus domain. On that toggle the snapshot is loaded into a pair of 32-bit holding registers, and the latch bit drops back to zero.

The two holding registers always come from one snapshot, so the low and high words belong to the same counter value. They keep that value until the next capture completes. Software must wait until the latch bit reads 0 before it trusts either word. A single asynchronous reset input is synchronized separately into each clock domain.

Top module: `snap_ctr_apb`

## Requirements
- R1: After reset is released, the counter starts from zero and advances by exactly one on every rising edge of `cnt_clk`. A reset applied later returns it to zero.
- R2: While reset is held and just after it is released, the control word, the low word and the high word all read as zero.
- R3: Writing a word with bit 1 set to offset 0x0 starts a capture. Bit 1 of the control word then reads 1 until the capture has finished, and reads 0 afterwards.
- R4: A capture completes within 3 `cnt_clk` cycles after the request reaches the counter domain. The latch bit clears a few bus cycles later, well inside 8 consecutive control reads.
- R5: Once the latch bit reads 0, the low word (offset 0x4) and the high word (offset 0x8) together form one 64-bit counter value. That value is no smaller than the count when the request was written and no larger than the count when the clear was observed.
- R6: Between captures the holding registers and the counter-domain snapshot keep their contents unchanged.
- R7: A write with bit 1 set made while a capture is pending starts no second capture. Writing 0 to the control register has no effect.
- R8: Registers sit at word offsets 0x0 (control, latch bit at position 1, all other bits read 0), 0x4 (low word) and 0x8 (high word). Every other offset reads as zero, and `pready` is always 1.
- R9: Captures taken one after another give non-decreasing 64-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| cnt_clk | input | 1 | Counter clock, asynchronous to `pclk` |
| arst_n | input | 1 | Active-low asynchronous reset for both domains |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |

## Verification
A write to the latch bit takes effect on the same `pclk` edge that ends the access phase. For that reason, a control read issued straight after the write must already show bit 1 set. The capture itself needs two synchronizer stages plus one capture edge in `cnt_clk`, followed by two synchronizer stages and one detection edge in `pclk`. The bench therefore polls the control register instead of waiting a fixed time, and it allows a bounded number of polls (8) before it reports a failure. Because the bus samples at unrelated instants, each captured value is checked against a window of reference `cnt_clk` edges. The window is bounded by edges counted before the write and after the clear was seen, and it allows for the two-cycle reset synchronizer in the counter domain.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned LATCH_BIT = 1;
  localparam logic [31:0] OFS_CTRL = 32'h0;
  localparam logic [31:0] OFS_LO   = 32'h4;
  localparam logic [31:0] OFS_HI   = 32'h8;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_LO, SEL_HI} reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] addr);
    if (addr == OFS_CTRL) return SEL_CTRL;
    if (addr == OFS_LO)   return SEL_LO;
    if (addr == OFS_HI)   return SEL_HI;
    return SEL_NONE;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic busy);
    logic [31:0] w;
    w = '0;
    w[LATCH_BIT] = busy;
    return w;
  endfunction

  function automatic logic [63:0] count_next(input logic [63:0] c);
    return c + 64'd1;
  endfunction
endpackage

// File: rtl/snap_rst_sync.sv
module snap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/snap_bit_sync.sv
module snap_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] flops;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flops <= '0;
        else        flops <= d_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flops <= '0;
        else        flops <= {flops[STAGES-2:0], d_async};
    end
  endgenerate

  assign q = flops[STAGES-1];
endmodule

// File: rtl/snap_cnt_dom.sv
module snap_cnt_dom
  import snap_pkg::*;
#(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl_async,
  output logic [CNT_W-1:0] snap,
  output logic             ack_tgl
);
  logic [CNT_W-1:0] cnt;
  logic             req_s;
  logic             req_seen;
  logic             req_edge;

  snap_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_tgl_async), .q(req_s)
  );

  assign req_edge = req_s ^ req_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(count_next(64'(cnt)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap     <= '0;
      ack_tgl  <= 1'b0;
      req_seen <= 1'b0;
    end else if (req_edge) begin
      snap     <= cnt;
      ack_tgl  <= ~ack_tgl;
      req_seen <= req_s;
    end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4
  cap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_edge |=> ack_tgl != $past(ack_tgl));

  // R6
  snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_edge |=> $stable(snap));
endmodule

// File: rtl/snap_bus_regs.sv
module snap_bus_regs
  import snap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HALF_W     = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [CNT_W-1:0]  snap_async,
  input  logic              ack_tgl_async,
  output logic              req_tgl
);
  reg_sel_e         sel;
  logic             busy;
  logic             ack_s;
  logic             ack_seen;
  logic             ack_evt;
  logic             wr_ctrl;
  logic             start_evt;
  logic [CNT_W-1:0] hold;
  logic             unused_wdata;

  assign sel          = decode_sel(32'(paddr));
  assign wr_ctrl      = psel && penable && pwrite && (sel == SEL_CTRL);
  assign start_evt    = wr_ctrl && pwdata[LATCH_BIT] && !busy;
  assign unused_wdata = ^pwdata;
  assign pready       = 1'b1;

  snap_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ack_tgl_async), .q(ack_s)
  );

  assign ack_evt = ack_s ^ ack_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      req_tgl  <= 1'b0;
      ack_seen <= 1'b0;
      hold     <= '0;
    end else begin
      ack_seen <= ack_s;
      if (ack_evt) begin
        busy <= 1'b0;
        hold <= snap_async;
      end else if (start_evt) begin
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
      end
    end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        SEL_CTRL: prdata = ctrl_word(busy);
        SEL_LO:   prdata = 32'(hold[HALF_W-1:0]);
        SEL_HI:   prdata = 32'(hold[CNT_W-1:HALF_W]);
        default:  prdata = '0;
      endcase
    end
  end

  // R3
  latch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_ctrl && pwdata[LATCH_BIT]));

  // R4
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ack_evt));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_evt |=> $stable(hold));

  // R7
  pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl) |=> req_tgl == $past(req_tgl));
endmodule

// File: rtl/snap_ctr_apb.sv
module snap_ctr_apb #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              pclk,
  input  logic              cnt_clk,
  input  logic              arst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready
);
  logic             bus_rst_n;
  logic             cnt_rst_n;
  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] snap;

  snap_rst_sync #(.STAGES(RST_STAGES)) u_bus_rst (
    .clk(pclk), .arst_n(arst_n), .rst_n(bus_rst_n)
  );

  snap_rst_sync #(.STAGES(RST_STAGES)) u_cnt_rst (
    .clk(cnt_clk), .arst_n(arst_n), .rst_n(cnt_rst_n)
  );

  snap_cnt_dom #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .req_tgl_async(req_tgl),
    .snap(snap), .ack_tgl(ack_tgl)
  );

  snap_bus_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(pclk), .rst_n(bus_rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .snap_async(snap), .ack_tgl_async(ack_tgl),
    .req_tgl(req_tgl)
  );
endmodule

// File: tb/test_snap_ctr_apb.sv
module test_snap_ctr_apb;
  logic        pclk = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;

  int checks = 0;
  int errors = 0;
  longint unsigned cref = 0;
  logic [63:0] last_val = '0;

  localparam int POLL_MAX = 8;

  always #10 pclk = ~pclk;
  always #20.5 cnt_clk = ~cnt_clk;

  always @(posedge cnt_clk or negedge arst_n)
    if (!arst_n) cref <= 0;
    else         cref <= cref + 1;

  snap_ctr_apb i_snap_ctr_apb (
    .pclk(pclk), .cnt_clk(cnt_clk), .arst_n(arst_n), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    check(pready === 1'b1, "R8 pready", {63'b0, pready}, 64'd1);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // start a capture, poll it to completion, return the 64-bit value
  task automatic capture(input logic [31:0] wval, input bit double_write,
                         output logic [63:0] val);
    logic [31:0] r, lo, hi;
    longint unsigned cw, cc;
    int polls;
    cw = cref;
    bus_write(8'h0, wval);
    if (double_write) bus_write(8'h0, wval);
    else begin
      bus_read(8'h0, r);
      check(r == 32'h2, "R3 latch bit set after write", 64'(r), 64'h2);
    end
    polls = 0;
    r = 32'h2;
    while (r[1] && polls < POLL_MAX) begin
      bus_read(8'h0, r);
      polls++;
    end
    cc = cref;
    check(r == 32'h0, "R4 latch bit cleared within poll bound", 64'(r), 64'h0);
    bus_read(8'h4, lo);
    bus_read(8'h8, hi);
    val = {hi, lo};
    check(val + 3 >= 64'(cw) && val <= 64'(cc), "R5 capture within reference window",
          val, 64'(cw));
  endtask

  task automatic t_reset_state();
    logic [31:0] r;
    bus_read(8'h0, r); check(r == 0, "R2 ctrl after reset", 64'(r), 0);
    bus_read(8'h4, r); check(r == 0, "R2 low after reset", 64'(r), 0);
    bus_read(8'h8, r); check(r == 0, "R2 high after reset", 64'(r), 0);
  endtask

  task automatic t_zero_write();
    logic [31:0] r;
    bus_write(8'h0, 32'h0);
    repeat (30) @(negedge pclk);
    bus_read(8'h0, r); check(r == 0, "R7 write 0 leaves ctrl", 64'(r), 0);
    bus_read(8'h4, r); check(r == 0, "R7 write 0 starts no capture", 64'(r), 0);
  endtask

  task automatic t_captures();
    logic [63:0] v;
    for (int i = 0; i < 4; i++) begin
      repeat (50 + 37 * i) @(negedge pclk);
      capture(32'h2, 1'b0, v);
      check(v >= last_val, "R9 monotonic captures", v, last_val);
      last_val = v;
    end
  endtask

  task automatic t_hold();
    logic [31:0] lo, hi;
    repeat (300) @(negedge pclk);
    bus_read(8'h4, lo);
    bus_read(8'h8, hi);
    check({hi, lo} == last_val, "R6 holding registers keep value", {hi, lo}, last_val);
  endtask

  task automatic t_pending_write();
    logic [63:0] v;
    logic [31:0] r, lo;
    capture(32'h2, 1'b1, v);
    check(v >= last_val, "R9 monotonic after double write", v, last_val);
    last_val = v;
    repeat (200) @(negedge pclk);
    bus_read(8'h0, r);
    check(r == 0, "R7 second write started no capture", 64'(r), 0);
    bus_read(8'h4, lo);
    check(lo == last_val[31:0], "R7 no extra capture loaded", 64'(lo), 64'(last_val[31:0]));
  endtask

  task automatic t_map();
    logic [31:0] r;
    logic [63:0] v;
    bus_read(8'h0C, r); check(r == 0, "R8 offset 0xC reads zero", 64'(r), 0);
    bus_read(8'h10, r); check(r == 0, "R8 offset 0x10 reads zero", 64'(r), 0);
    bus_read(8'h06, r); check(r == 0, "R8 offset 0x6 reads zero", 64'(r), 0);
    bus_write(8'h4, 32'h2);
    bus_read(8'h0, r); check(r == 0, "R8 write to low word starts nothing", 64'(r), 0);
    capture(32'hFFFF_FFFF, 1'b0, v);
    check(v >= last_val, "R9 monotonic with all-ones write", v, last_val);
    last_val = v;
  endtask

  task automatic t_reset_again();
    logic [63:0] v;
    #3;
    arst_n = 1'b0;
    repeat (5) @(negedge pclk);
    t_reset_state();
    #7;
    arst_n = 1'b1;
    t_reset_state();
    repeat (20) @(negedge pclk);
    capture(32'h2, 1'b0, v);
    check(v <= 64'(cref), "R1 counter restarted from zero", v, 64'(cref));
    check(v < last_val, "R1 count below pre-reset value", v, last_val);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge pclk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #33;
    t_reset_state();
    arst_n = 1'b1;
    repeat (4) @(negedge pclk);
    t_reset_state();
    t_zero_write();
    t_captures();
    t_hold();
    t_pending_write();
    t_map();
    t_reset_again();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule